// File: doc/BRIEF.md
# Configuration window address translator

This block sits between a configuration request source and a memory-mapped configuration window. Each request names a bus number, a device/function number and a register offset. The block first decides whether the request may reach the window at all. If it may, the block turns the three fields into a 64-bit address inside the window. If it may not, the request is refused and the requester gets a defined result instead of a window access.

Two rules decide whether a request is refused. On the root bus only device/function 0 exists. Any bus below the root is reachable only while the link-up status bit is set. Refusal is also forced whenever translation is switched off. A refused read completes with all-ones data, and a refused write is dropped.

A small word-indexed register interface carries four registers:
- a read-only presence flag;
- a control word holding the enable and the window size field (read back as the last valid bus number);
- the low and high words of the window base.

Every request gets its outcome on the cycle after it is presented.

Top module: `cfgwin_xlat`

## Requirements
- R1: An accepted request produces, one cycle after req_valid, xl_valid high and xl_addr equal to base + (bus << 20) + (devfn << 12) + offset in 64-bit arithmetic with wrap-around. The same cycle, out_write repeats the request direction and, for a write, out_wdata repeats the request data.
- R2: A request to the root bus (bus number ROOT_BUS, default 0) with a device/function value other than 0 is refused: one cycle later rej_valid is high and xl_valid is low.
- R3: A request to any bus other than ROOT_BUS is refused while link_up is 0 and accepted while link_up is 1, provided translation is enabled.
- R4: While the control enable bit (control bit 0) is 0, every request is refused, whatever the bus, device/function or link state.
- R5: A refused read (req_write = 0) shows rej_rdata = 0xFFFFFFFF in its rej_valid cycle. A refused write shows rej_rdata = 0 and raises no xl_valid, so nothing reaches the window.
- R6: Register index 0 is the presence register. It reads 0x00000001 when the translator is present, and writes to it have no effect.
- R7: Register index 1 is the control register. Bit 0 is the enable and bits 20:16 are the window size field; all other bits read 0. After reset it reads 0x000C0000, which is enable clear and size 12.
- R8: Register indices 2 and 3 hold the low and high 32-bit words of the window base. Both reset to 0 and read back what was written.
- R9: After reset, xl_valid and rej_valid are low.
- R10: Each request yields exactly one of xl_valid or rej_valid on the following cycle. A cycle without a request yields neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index (0 presence, 1 control, 2 base low, 3 base high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| link_up | input | 1 | Link-up status bit |
| req_valid | input | 1 | Configuration request strobe |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_bus | input | BUS_W | Target bus number |
| req_devfn | input | DF_W | Target device/function number |
| req_off | input | OFF_W | Register offset within the function |
| req_wdata | input | 32 | Write data of the request |
| xl_valid | output | 1 | Accepted request, xl_addr valid |
| xl_addr | output | 64 | Translated window address |
| out_write | output | 1 | Direction of the request just completed |
| out_wdata | output | 32 | Write data of an accepted write |
| rej_valid | output | 1 | Refused request |
| rej_rdata | output | 32 | Completion data of a refused request |

## Verification
The bench sweeps every bus number against several device/function values, both link states and both directions. This catches a design that compares the wrong field with zero on the root bus, or that gates the root bus on the link state: it would refuse or pass the wrong requests. The window base is placed so that adding the bus field carries into the high word; an adder narrower than 64 bits, or an OR in place of the add, would then give a wrong high word. Disabled sweeps, refused writes checked for all-zero data with no xl_valid, and a write of all ones to the control and presence registers catch leaks past the enable and writable bits that should read zero.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

   localparam int ADDR_W    = 64;
   localparam int DATA_W    = 32;
   localparam int SEL_W     = 2;
   localparam int SIZE_W    = 5;
   localparam int SIZE_LSB  = 16;
   localparam int EN_BIT    = 0;
   localparam int DEV_SHIFT = 12;
   localparam int BUS_SHIFT = 20;

   localparam logic [SEL_W-1:0] SEL_CAP     = 2'd0;
   localparam logic [SEL_W-1:0] SEL_CTRL    = 2'd1;
   localparam logic [SEL_W-1:0] SEL_BASE_LO = 2'd2;
   localparam logic [SEL_W-1:0] SEL_BASE_HI = 2'd3;

endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
   import cfgwin_pkg::*;
#(
   parameter bit PRESENT  = 1'b1,
   parameter int SIZE_RST = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [SEL_W-1:0]    reg_sel,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                enable,
   output logic [SIZE_W-1:0]   win_size,
   output logic [ADDR_W-1:0]   win_base
);

   if (SIZE_RST >= (1 << SIZE_W)) begin : g_bad_size
      $error("SIZE_RST does not fit the size field");
   end

   logic [DATA_W-1:0] ctrl_word;

   if (PRESENT) begin : g_present
      logic                en_q;
      logic [SIZE_W-1:0]   size_q;
      logic [DATA_W-1:0]   base_lo_q, base_hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q      <= 1'b0;
            size_q    <= SIZE_W'(SIZE_RST);
            base_lo_q <= '0;
            base_hi_q <= '0;
         end else if (reg_we) begin
            case (reg_sel)
               SEL_CTRL: begin
                  en_q   <= reg_wdata[EN_BIT];
                  size_q <= reg_wdata[SIZE_LSB +: SIZE_W];
               end
               SEL_BASE_LO: base_lo_q <= reg_wdata;
               SEL_BASE_HI: base_hi_q <= reg_wdata;
               default: ;
            endcase
         end
      end

      assign enable   = en_q;
      assign win_size = size_q;
      assign win_base = {base_hi_q, base_lo_q};

      // R7: control write lands in the fields on the next cycle
      a_r7_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && reg_sel == SEL_CTRL) |=>
            (enable == $past(reg_wdata[EN_BIT]) &&
             win_size == $past(reg_wdata[SIZE_LSB +: SIZE_W])));

      // R8: high base word holds what was written
      a_r8_base_hi: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && reg_sel == SEL_BASE_HI) |=>
            (win_base[ADDR_W-1:DATA_W] == $past(reg_wdata)));
   end else begin : g_absent
      assign enable   = 1'b0;
      assign win_size = '0;
      assign win_base = '0;
   end

   always_comb begin
      ctrl_word                       = '0;
      ctrl_word[EN_BIT]               = enable;
      ctrl_word[SIZE_LSB +: SIZE_W]   = win_size;
   end

   always_comb begin
      case (reg_sel)
         SEL_CAP:     reg_rdata = DATA_W'(PRESENT);
         SEL_CTRL:    reg_rdata = ctrl_word;
         SEL_BASE_LO: reg_rdata = win_base[DATA_W-1:0];
         default:     reg_rdata = win_base[ADDR_W-1:DATA_W];
      endcase
   end

endmodule

// File: rtl/cfgwin_gate.sv
module cfgwin_gate
   import cfgwin_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int DF_W     = 8,
   parameter int ROOT_BUS = 0
) (
   input  logic              enable,
   input  logic              link_up,
   input  logic [BUS_W-1:0]  bus,
   input  logic [DF_W-1:0]   devfn,
   output logic              reject
);

   localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

   logic on_root;
   logic root_bad;
   logic down_bad;

   assign on_root  = (bus == ROOT);
   assign root_bad = on_root && (devfn != '0);
   assign down_bad = !on_root && !link_up;
   assign reject   = !enable || root_bad || down_bad;

endmodule

// File: rtl/cfgwin_addr.sv
module cfgwin_addr
   import cfgwin_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int DF_W  = 8,
   parameter int OFF_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               reject,
   input  logic [BUS_W-1:0]   bus,
   input  logic [DF_W-1:0]    devfn,
   input  logic [OFF_W-1:0]   off,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [ADDR_W-1:0]  win_base,
   output logic               xl_valid,
   output logic [ADDR_W-1:0]  xl_addr,
   output logic               out_write,
   output logic [DATA_W-1:0]  out_wdata,
   output logic               rej_valid,
   output logic [DATA_W-1:0]  rej_rdata
);

   logic [ADDR_W-1:0] rel;
   logic [ADDR_W-1:0] sum;
   logic              take;

   assign rel  = (ADDR_W'(bus) << BUS_SHIFT) | (ADDR_W'(devfn) << DEV_SHIFT);
   assign sum  = win_base + rel + ADDR_W'(off);
   assign take = req_valid && !reject;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_valid  <= 1'b0;
         rej_valid <= 1'b0;
         xl_addr   <= '0;
         out_write <= 1'b0;
         out_wdata <= '0;
         rej_rdata <= '0;
      end else begin
         xl_valid  <= take;
         rej_valid <= req_valid && reject;
         rej_rdata <= (req_valid && reject && !req_write) ? '1 : '0;
         if (req_valid) out_write <= req_write;
         if (take) xl_addr <= sum;
         if (take && req_write) out_wdata <= wdata;
      end
   end

endmodule

// File: rtl/cfgwin_xlat.sv
module cfgwin_xlat
   import cfgwin_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int DF_W     = 8,
   parameter int OFF_W    = 12,
   parameter int ROOT_BUS = 0,
   parameter bit PRESENT  = 1'b1,
   parameter int SIZE_RST = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_sel,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               link_up,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [BUS_W-1:0]   req_bus,
   input  logic [DF_W-1:0]    req_devfn,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [31:0]        req_wdata,
   output logic               xl_valid,
   output logic [63:0]        xl_addr,
   output logic               out_write,
   output logic [31:0]        out_wdata,
   output logic               rej_valid,
   output logic [31:0]        rej_rdata
);

   if (OFF_W > DEV_SHIFT) begin : g_bad_off
      $error("OFF_W overlaps the device/function field");
   end
   if (DF_W > BUS_SHIFT - DEV_SHIFT) begin : g_bad_df
      $error("DF_W overlaps the bus field");
   end
   if (BUS_W + BUS_SHIFT > ADDR_W) begin : g_bad_bus
      $error("BUS_W does not fit the address");
   end
   if (ROOT_BUS >= (1 << BUS_W)) begin : g_bad_root
      $error("ROOT_BUS does not fit BUS_W");
   end

   localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

   logic               enable;
   logic [SIZE_W-1:0]  win_size;
   logic [ADDR_W-1:0]  win_base;
   logic               reject;

   cfgwin_regs #(.PRESENT(PRESENT), .SIZE_RST(SIZE_RST)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .enable    (enable),
      .win_size  (win_size),
      .win_base  (win_base)
   );

   cfgwin_gate #(.BUS_W(BUS_W), .DF_W(DF_W), .ROOT_BUS(ROOT_BUS)) u_gate (
      .enable  (enable),
      .link_up (link_up),
      .bus     (req_bus),
      .devfn   (req_devfn),
      .reject  (reject)
   );

   cfgwin_addr #(.BUS_W(BUS_W), .DF_W(DF_W), .OFF_W(OFF_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .reject    (reject),
      .bus       (req_bus),
      .devfn     (req_devfn),
      .off       (req_off),
      .wdata     (req_wdata),
      .win_base  (win_base),
      .xl_valid  (xl_valid),
      .xl_addr   (xl_addr),
      .out_write (out_write),
      .out_wdata (out_wdata),
      .rej_valid (rej_valid),
      .rej_rdata (rej_rdata)
   );

   // R2: non-zero function on the root bus is refused
   a_r2_root_fn0_only: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bus == ROOT && req_devfn != '0) |=> (rej_valid && !xl_valid));

   // R3: downstream bus with link down is refused
   a_r3_link_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bus != ROOT && !link_up) |=> (rej_valid && !xl_valid));

   // R4: disabled translation refuses everything
   a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !enable) |=> (rej_valid && !xl_valid));

   // R5: refused read returns all ones, refused write returns zero
   a_r5_rej_data: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid |-> (rej_rdata == (out_write ? 32'h0 : 32'hFFFF_FFFF)));

   // R10: one outcome per request
   a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ($countones({xl_valid, rej_valid}) == 1));

   // R10: no outcome without a request
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!xl_valid && !rej_valid));

endmodule

// File: tb/test_cfgwin_xlat.sv
`timescale 1ns/1ps
module test_cfgwin_xlat;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        link_up = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [7:0]  req_devfn = '0;
   logic [11:0] req_off = '0;
   logic [31:0] req_wdata = '0;
   logic        xl_valid;
   logic [63:0] xl_addr;
   logic        out_write;
   logic [31:0] out_wdata;
   logic        rej_valid;
   logic [31:0] rej_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [63:0] base_m = '0;
   bit          en_m   = 1'b0;

   always #2 clk = ~clk;

   cfgwin_xlat i_cfgwin_xlat (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
      .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
      .req_devfn(req_devfn), .req_off(req_off), .req_wdata(req_wdata),
      .xl_valid(xl_valid), .xl_addr(xl_addr), .out_write(out_write),
      .out_wdata(out_wdata), .rej_valid(rej_valid), .rej_rdata(rej_rdata));

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (sel == 2'd1) en_m = d[0];
      if (sel == 2'd2) base_m[31:0] = d;
      if (sel == 2'd3) base_m[63:32] = d;
   endtask

   task automatic reg_check(input logic [1:0] sel, input logic [31:0] exp,
                            input string tag);
      @(negedge clk);
      reg_sel = sel;
      #1;
      check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic do_req(input bit wr, input logic [7:0] bus,
                         input logic [7:0] df, input logic [11:0] off,
                         input bit lk);
      bit          refuse;
      string       tag;
      logic [63:0] exp_addr;
      logic [31:0] wd;
      wd = {bus, df, 4'h5, off};
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_bus = bus; req_devfn = df;
      req_off = off; req_wdata = wd; link_up = lk;
      refuse = !en_m || (bus == 8'd0 && df != 8'd0) || (bus != 8'd0 && !lk);
      if (!en_m)                      tag = "R4 disabled";
      else if (bus == 8'd0)           tag = "R2 root bus";
      else                            tag = "R3 link gate";
      exp_addr = base_m + (64'(bus) << 20) + (64'(df) << 12) + 64'(off);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      if (refuse) begin
         check(rej_valid && !xl_valid, tag, {62'b0, xl_valid, rej_valid}, 64'd1);
         check(rej_rdata == (wr ? 32'h0 : 32'hFFFF_FFFF), "R5 refused data",
               64'(rej_rdata), wr ? 64'h0 : 64'hFFFF_FFFF);
      end else begin
         check(xl_valid && !rej_valid, tag, {62'b0, xl_valid, rej_valid}, 64'd2);
         check(xl_addr == exp_addr && out_write == wr && (!wr || out_wdata == wd),
               "R1 address", xl_addr, exp_addr);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] dfs [4];
      dfs[0] = 8'd0; dfs[1] = 8'd1; dfs[2] = 8'd7; dfs[3] = 8'd255;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(!xl_valid && !rej_valid, "R9 reset outputs",
            {62'b0, xl_valid, rej_valid}, 64'd0);
      reg_check(2'd0, 32'h0000_0001, "R6 presence");
      reg_check(2'd1, 32'h000C_0000, "R7 control reset");
      reg_check(2'd2, 32'h0, "R8 base lo reset");
      reg_check(2'd3, 32'h0, "R8 base hi reset");

      reg_write(2'd0, 32'hFFFF_FFFF);
      reg_check(2'd0, 32'h0000_0001, "R6 write ignored");
      reg_write(2'd1, 32'hFFFF_FFFF);
      reg_check(2'd1, 32'h001F_0001, "R7 writable bits");
      reg_write(2'd1, 32'h000C_0000);
      reg_write(2'd2, 32'hFFF0_1234);
      reg_write(2'd3, 32'h0000_00A5);
      reg_check(2'd2, 32'hFFF0_1234, "R8 base lo");
      reg_check(2'd3, 32'h0000_00A5, "R8 base hi");

      // R4: disabled, every combination refused
      for (int b = 0; b < 4; b++)
         for (int d = 0; d < 4; d++)
            do_req(d[0], 8'(b * 60), dfs[d], 12'h010, 1'b1);

      reg_write(2'd1, 32'h000C_0001);
      reg_check(2'd1, 32'h000C_0001, "R7 enable set");

      // R1 R2 R3 sweep
      for (int b = 0; b < 256; b++)
         for (int d = 0; d < 4; d++)
            for (int l = 0; l < 2; l++)
               do_req((b + d + l) % 2 == 1, 8'(b), dfs[d],
                      12'((b * 37 + d * 11 + l * 1000) % 4096), l[0]);

      // R1 wrap-around of the 64-bit sum
      reg_write(2'd2, 32'hFFFF_FFFC);
      reg_write(2'd3, 32'hFFFF_FFFF);
      do_req(1'b0, 8'd0, 8'd0, 12'h008, 1'b0);
      do_req(1'b1, 8'd255, 8'd255, 12'hFFF, 1'b1);

      // R10: idle cycle gives no outcome
      @(negedge clk);
      #1;
      check(!xl_valid && !rej_valid, "R10 idle", {62'b0, xl_valid, rej_valid}, 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule